// File: doc/BRIEF.md
# CPU idle phase sequencer

This block walks one processor core through a low-power episode. When the core is running and raises an idle request, the sequencer captures the timing of the chosen state. It then moves through an optional, abortable preparation phase and a committed entry phase into the idle phase. It waits there for a wake event, runs an exit phase and hands the core back to normal execution. Each duration is a cycle count supplied with the request.

The preparation phase is the only point where the core can back out. A wake seen there returns the core at once. A wake seen once entry has begun is held until entry finishes, and it is then served with the full exit time. A plain standby request skips every timed phase and only waits for a wake. The block reports whether the core's local timer state survives the episode. It also marks the return to execution with a one-cycle pulse that tells a completed episode from an aborted one.

Top module: `idle_phase_seq`

## Requirements
- R1: `phase` reports EXEC=0, PREP=1, ENTRY=2, IDLE=3 and EXIT=4, visited only in that order (PREP may be skipped, and only PREP may return early to EXEC). `core_run` is high exactly while `phase` is EXEC.
- R2: With `prep_en`=1, PREP lasts max(`prep_len`,1) cycles and ENTRY lasts max(`entry_len`,1) cycles. With `prep_en`=0, PREP is skipped and ENTRY lasts max(`entry_len`+`prep_len`,1) cycles, and that sum does not wrap.
- R3: EXIT lasts max(`exit_len`,1) cycles.
- R4: A wake sampled during PREP makes the next cycle EXEC, with `abort_pulse` high.
- R5: A wake during ENTRY does not shorten ENTRY. It is held, so IDLE lasts exactly one cycle and is followed by a full EXIT.
- R6: IDLE lasts until a wake is sampled, and the following cycle is EXIT.
- R7: When `timer_stop` was set at acceptance, `timer_kept` is low from ENTRY until the return to EXEC. Otherwise it stays high.
- R8: A request with `standby`=1 goes straight to IDLE, and a wake then returns the core to EXEC the next cycle, with `done_pulse` high and `timer_kept` high throughout.
- R9: `done_pulse` (after IDLE or EXIT) and `abort_pulse` (after PREP) are high only in the first EXEC cycle of a return, never together.
- R10: All lengths and flags are captured when the request is accepted. Later changes to them have no effect on the running episode.
- R11: A wake during EXEC, and an idle request outside EXEC, have no effect.
- R12: After reset, `phase` is EXEC, `core_run` and `timer_kept` are high, and both pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idle_req | input | 1 | Request to start an idle episode (taken in EXEC only) |
| wake | input | 1 | Wake event |
| prep_en | input | 1 | State has an abortable preparation phase |
| prep_len | input | CNT_W | Preparation length in cycles |
| entry_len | input | CNT_W | Entry length in cycles |
| exit_len | input | CNT_W | Exit length in cycles |
| timer_stop | input | 1 | State loses local timer control |
| standby | input | 1 | Plain standby, no timed phases |
| phase | output | 3 | Current phase code |
| core_run | output | 1 | Core may execute |
| timer_kept | output | 1 | Local timer control is retained |
| done_pulse | output | 1 | Return after a completed episode |
| abort_pulse | output | 1 | Return after an aborted preparation |

## Verification
The bench builds the block with CNT_W=8, so every length fits a byte, while a folded preparation-plus-entry sum of 400 cycles must use the extra counter bit. Zero lengths, aborts on the first and a middle preparation cycle, and wakes early in entry and on its last cycle are all reached within a few hundred cycles. A long row checks that the widened entry count does not wrap.

// File: rtl/idle_phase_seq.sv
module idle_phase_seq #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle_req,
  input  logic             wake,
  input  logic             prep_en,
  input  logic [CNT_W-1:0] prep_len,
  input  logic [CNT_W-1:0] entry_len,
  input  logic [CNT_W-1:0] exit_len,
  input  logic             timer_stop,
  input  logic             standby,
  output logic [2:0]       phase,
  output logic             core_run,
  output logic             timer_kept,
  output logic             done_pulse,
  output logic             abort_pulse
);
  localparam int LW = CNT_W + 1;
  localparam logic [2:0] PH_RUN = 3'd0, PH_PREP = 3'd1, PH_COMMIT = 3'd2,
                         PH_IDLE = 3'd3, PH_WAKE = 3'd4;

  logic [LW-1:0]    cnt, entry_r;
  logic [CNT_W-1:0] exit_r;
  logic             stop_r, stby_r, pend;

  wire          last      = (cnt <= LW'(1));
  wire [LW-1:0] entry_sum = {1'b0, entry_len} + (prep_en ? {LW{1'b0}} : {1'b0, prep_len});

  assign core_run   = (phase == PH_RUN);
  assign timer_kept = !(stop_r && (phase == PH_COMMIT || phase == PH_IDLE || phase == PH_WAKE));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase       <= PH_RUN;
      cnt         <= '0;
      entry_r     <= '0;
      exit_r      <= '0;
      stop_r      <= 1'b0;
      stby_r      <= 1'b0;
      pend        <= 1'b0;
      done_pulse  <= 1'b0;
      abort_pulse <= 1'b0;
    end else begin
      done_pulse  <= 1'b0;
      abort_pulse <= 1'b0;
      case (phase)
        PH_RUN: if (idle_req) begin
          entry_r <= entry_sum;
          exit_r  <= exit_len;
          stop_r  <= timer_stop && !standby;
          stby_r  <= standby;
          pend    <= 1'b0;
          if (standby) phase <= PH_IDLE;
          else if (prep_en) begin
            phase <= PH_PREP;
            cnt   <= {1'b0, prep_len};
          end else begin
            phase <= PH_COMMIT;
            cnt   <= entry_sum;
          end
        end
        PH_PREP: begin
          if (wake) begin
            phase       <= PH_RUN;
            abort_pulse <= 1'b1;
          end else if (last) begin
            phase <= PH_COMMIT;
            cnt   <= entry_r;
          end else cnt <= cnt - LW'(1);
        end
        PH_COMMIT: begin
          if (wake) pend <= 1'b1;
          if (last) phase <= PH_IDLE;
          else cnt <= cnt - LW'(1);
        end
        PH_IDLE: if (wake || pend) begin
          pend <= 1'b0;
          if (stby_r) begin
            phase      <= PH_RUN;
            done_pulse <= 1'b1;
          end else begin
            phase <= PH_WAKE;
            cnt   <= {1'b0, exit_r};
          end
        end
        PH_WAKE: begin
          if (last) begin
            phase      <= PH_RUN;
            done_pulse <= 1'b1;
          end else cnt <= cnt - LW'(1);
        end
        default: phase <= PH_RUN;
      endcase
    end
  end
endmodule

// File: rtl/idle_phase_seq_chk.sv
module idle_phase_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       idle_req,
  input logic       wake,
  input logic [2:0] phase,
  input logic       done_pulse,
  input logic       abort_pulse
);
  // R4
  prep_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd1 && wake) |=> (phase == 3'd0 && abort_pulse));

  // R5
  entry_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd2) |=> (phase == 3'd2 || phase == 3'd3));

  // R6
  idle_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd3 && wake) |=> (phase == 3'd4 || phase == 3'd0));

  // R9
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_pulse, abort_pulse}));

  // R9
  done_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> (phase == 3'd0 && ($past(phase) == 3'd4 || $past(phase) == 3'd3)));

  // R11
  exec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd0 && !idle_req) |=> (phase == 3'd0));

  // R1
  exit_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd4) |=> (phase == 3'd4 || phase == 3'd0));
endmodule

bind idle_phase_seq idle_phase_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .wake(wake),
  .phase(phase), .done_pulse(done_pulse), .abort_pulse(abort_pulse)
);

// File: tb/sim_idle_phase_seq.sv
module sim_idle_phase_seq;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n, idle_req, wake, prep_en, timer_stop, standby;
  logic [W-1:0] prep_len, entry_len, exit_len;
  logic [2:0] phase;
  logic core_run, timer_kept, done_pulse, abort_pulse;

  idle_phase_seq #(.CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .wake(wake),
    .prep_en(prep_en), .prep_len(prep_len), .entry_len(entry_len),
    .exit_len(exit_len), .timer_stop(timer_stop), .standby(standby),
    .phase(phase), .core_run(core_run), .timer_kept(timer_kept),
    .done_pulse(done_pulse), .abort_pulse(abort_pulse)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic hp; logic [7:0] p, e, x; logic st, sb; logic [7:0] w, ap, ew; logic chg;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'd3,   8'd4,   8'd5, 1'b0, 1'b0, 8'd2,  8'd0, 8'd0, 1'b0},
    '{1'b0, 8'd3,   8'd4,   8'd2, 1'b1, 1'b0, 8'd1,  8'd0, 8'd0, 1'b0},
    '{1'b1, 8'd0,   8'd0,   8'd0, 1'b0, 1'b0, 8'd3,  8'd0, 8'd0, 1'b0},
    '{1'b1, 8'd5,   8'd5,   8'd5, 1'b1, 1'b1, 8'd4,  8'd0, 8'd0, 1'b0},
    '{1'b1, 8'd10,  8'd4,   8'd4, 1'b1, 1'b0, 8'd5,  8'd3, 8'd0, 1'b0},
    '{1'b1, 8'd10,  8'd4,   8'd4, 1'b0, 1'b0, 8'd5,  8'd1, 8'd0, 1'b0},
    '{1'b1, 8'd2,   8'd6,   8'd3, 1'b1, 1'b0, 8'd50, 8'd0, 8'd2, 1'b0},
    '{1'b1, 8'd2,   8'd3,   8'd4, 1'b0, 1'b0, 8'd2,  8'd0, 8'd0, 1'b1},
    '{1'b1, 8'd2,   8'd3,   8'd2, 1'b0, 1'b0, 8'd40, 8'd0, 8'd3, 1'b0},
    '{1'b0, 8'd200, 8'd200, 8'd1, 1'b0, 1'b0, 8'd1,  8'd0, 8'd0, 1'b0}
  };

  function automatic int max1(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  task automatic run_vec(input vec_t v);
    int np = 0, ne = 0, ni = 0, nx = 0, runbad = 0, guard = 0;
    int tk = 1;
    int ep, ee, ei, ex, etk;
    @(negedge clk);
    prep_en = v.hp; prep_len = v.p; entry_len = v.e; exit_len = v.x;
    timer_stop = v.st; standby = v.sb; idle_req = 1'b1;
    @(negedge clk);
    idle_req = 1'b0;
    if (v.chg) begin
      prep_len = 8'd200; entry_len = 8'd200; exit_len = 8'd200; timer_stop = ~v.st;
    end
    forever begin
      wake = 1'b0;
      if (core_run !== (phase == 3'd0)) runbad++;
      case (phase)
        3'd1: begin np++; if (np == int'(v.ap)) wake = 1'b1; end
        3'd2: begin ne++; if (ne == int'(v.ew)) wake = 1'b1; end
        3'd3: begin ni++; tk = timer_kept; if (ni == int'(v.w)) wake = 1'b1; end
        3'd4: nx++;
        default: ;
      endcase
      if (phase == 3'd0) break;
      guard++;
      if (guard > 2000) break;
      @(negedge clk);
    end
    if (v.ap != 0) begin
      ep = v.ap; ee = 0; ei = 0; ex = 0; etk = 1;
    end else if (v.sb) begin
      ep = 0; ee = 0; ei = v.w; ex = 0; etk = 1;
    end else begin
      ep  = v.hp ? max1(v.p) : 0;
      ee  = max1(int'(v.e) + (v.hp ? 0 : int'(v.p)));
      ei  = (v.ew != 0) ? 1 : int'(v.w);
      ex  = max1(v.x);
      etk = !v.st;
    end
    chk("R1", "core_run mismatches", runbad, 0);
    chk("R2/R4", "PREP cycles", np, ep);
    chk("R2/R10", "ENTRY cycles", ne, ee);
    chk("R6/R5/R8", "IDLE cycles", ni, ei);
    chk("R3/R10", "EXIT cycles", nx, ex);
    if (v.ap == 0) chk("R7/R10", "timer_kept in IDLE", tk, etk);
    chk("R9", "done_pulse on return", done_pulse, (v.ap == 0) ? 1 : 0);
    chk("R4", "abort_pulse on return", abort_pulse, (v.ap != 0) ? 1 : 0);
    @(negedge clk);
    chk("R9", "pulses one cycle", {30'd0, done_pulse, abort_pulse}, 0);
    prep_len = '0; entry_len = '0; exit_len = '0;
  endtask

  initial begin
    rst_n = 1'b0; idle_req = 1'b0; wake = 1'b0; prep_en = 1'b0;
    prep_len = '0; entry_len = '0; exit_len = '0; timer_stop = 1'b0; standby = 1'b0;
    repeat (3) @(negedge clk);
    // R12
    chk("R12", "reset phase", phase, 0);
    chk("R12", "reset core_run/timer_kept", {core_run, timer_kept}, 3);
    chk("R12", "reset pulses", {done_pulse, abort_pulse}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R11: wake while executing
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
    chk("R11", "phase after wake in EXEC", phase, 0);
    @(negedge clk);
    chk("R11", "pulses after wake in EXEC", {done_pulse, abort_pulse}, 0);

    // R11: idle request held while idle, R8 standby return
    standby = 1'b1; idle_req = 1'b1;
    @(negedge clk);
    chk("R8", "standby goes to IDLE", phase, 3);
    repeat (3) @(negedge clk);
    chk("R11", "request in IDLE ignored", phase, 3);
    idle_req = 1'b0; wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
    chk("R8", "standby wake returns to EXEC", phase, 0);
    chk("R8", "standby done_pulse", done_pulse, 1);
    standby = 1'b0;
    @(negedge clk);
    chk("R11", "no re-entry after return", phase, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule